// File: doc/BRIEF.md
# Register-List Stack Push/Pop Sequencer

This block moves a group of registers to or from a stack in memory, one register per clock cycle. An 8-bit register mask picks the registers, and a bank select chooses between the lower eight registers (0 to 7) and the upper eight (8 to 15). A word/byte select chooses whether the moved items are 16-bit registers or 8-bit register halves. A push/pop select gives the direction. The caller raises `start` for one cycle and supplies the current stack pointer. The sequencer then drives a register-file port and a 16-bit stack memory port. When the last register has moved, it presents the final stack pointer for a single write-back together with a one-cycle `done` pulse.

The controller has three states. From IDLE, a start with a non-empty mask goes to XFER, and a start with an empty mask goes straight to FINISH. XFER stays in XFER while set bits remain after the current one, and goes to FINISH after the last one. FINISH always returns to IDLE. In XFER a priority encoder selects the next set mask bit, so clear bits cost no cycle.

A push works from the highest mask bit down and lowers the stack pointer before each store. A pop works from the lowest mask bit up and raises the stack pointer after each load. Each entry takes a 2-byte slot even in byte mode. The register file and the memory are external: both return read data in the same cycle as the address.

Top module: `regmask_stack_seq`

## Requirements
- R1: After reset `done`, `busy`, `sp_we`, `mem_we`, `mem_re`, `rf_we` and `rf_re` are all low.
- R2: A push visits set mask bits from bit 7 down to bit 0, one per cycle. Each cycle it reads register `rf_idx` and stores it with `mem_we` high.
- R3: A push lowers the stack pointer by 2 before each store. The k-th store (k from 1) goes to address `sp_in - 2k`.
- R4: A pop visits set mask bits from bit 0 up to bit 7, one per cycle. The k-th load comes from address `sp_in + 2(k-1)`, and `rf_we` writes the loaded value to `rf_idx` in the same cycle.
- R5: `rf_idx` is `{bank, i}` for mask bit i. A bank value of 0 gives registers 0 to 7, and a value of 1 gives registers 8 to 15.
- R6: When word mode is low, `rf_word` is low and only bits 7:0 of the read data are used. A push stores `{8'h00, rf_rdata[7:0]}`, and a pop writes `{8'h00, mem_rdata[7:0]}` to the register file. When word mode is high, all 16 bits pass through.
- R7: Clear mask bits cost no cycle. With N set bits, `done` is high exactly N+1 cycles after the edge that samples `start`, and exactly N accesses occur.
- R8: `done` and `sp_we` are high together for exactly one cycle. At that point `sp_out` is `sp_in - 2N` for a push and `sp_in + 2N` for a pop.
- R9: An all-zero mask raises `done` in the cycle after start, with `sp_out` equal to `sp_in` and no memory or register access.
- R10: A `start` sampled while `busy` is high, including the cycle in which `done` is high, has no effect on the running operation or on later outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin an operation |
| is_pop | input | 1 | 1 selects pop, 0 selects push |
| word_mode | input | 1 | 1 selects 16-bit registers, 0 selects 8-bit halves |
| upper_bank | input | 1 | 1 selects registers 8-15, 0 selects registers 0-7 |
| reg_mask | input | 8 | Bit i selects register i of the bank |
| sp_in | input | 16 | Stack pointer at start |
| rf_idx | output | 4 | Register-file index |
| rf_word | output | 1 | Width of the register-file access |
| rf_re | output | 1 | Register-file read strobe (push) |
| rf_rdata | input | 16 | Register-file read data, same cycle |
| rf_we | output | 1 | Register-file write strobe (pop) |
| rf_wdata | output | 16 | Register-file write data |
| mem_addr | output | 16 | Stack memory byte address |
| mem_we | output | 1 | Stack memory write strobe |
| mem_wdata | output | 16 | Stack memory write data |
| mem_re | output | 1 | Stack memory read strobe |
| mem_rdata | input | 16 | Stack memory read data, same cycle |
| sp_out | output | 16 | Final stack pointer |
| sp_we | output | 1 | Stack pointer write-back strobe |
| done | output | 1 | Operation complete pulse |
| busy | output | 1 | High from the cycle after start until done |

## Verification
Two functions can meet in the same cycle: the completion of one operation (`done` and `sp_we` in FINISH) and the arrival of a new start request. A second case of the same kind is a start that arrives in the middle of XFER with different mode and mask inputs. The bench raises `start` exactly in the `done` cycle, and also in the first transfer cycle of an operation that moves two or more registers. It passes only if the running operation's scoreboard items arrive unchanged, and if the cycle after `done` shows `busy` low with no access and no second `done`.

// File: rtl/regmask_pkg.sv
package regmask_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/regmask_pick.sv
module regmask_pick #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     bits,
    input  logic             from_top,
    output logic [IDX_W-1:0] idx,
    output logic [W-1:0]     onehot
);
    logic any_set;
    assign any_set = |bits;

    // later writes win: ascending scan keeps the highest, descending the lowest
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (from_top) begin
                if (bits[i]) idx = IDX_W'(i);
            end else begin
                if (bits[W-1-i]) idx = IDX_W'(W-1-i);
            end
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_hot
        assign onehot[g] = any_set && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/regmask_sp_step.sv
module regmask_sp_step #(
    parameter int ADDR_W     = 16,
    parameter int SLOT_BYTES = 2
) (
    input  logic [ADDR_W-1:0] sp_cur,
    input  logic              go_down,
    output logic [ADDR_W-1:0] access_addr,
    output logic [ADDR_W-1:0] sp_next
);
    localparam logic [ADDR_W-1:0] SLOT_V = ADDR_W'(SLOT_BYTES);

    always_comb begin
        if (go_down) begin
            sp_next     = sp_cur - SLOT_V;
            access_addr = sp_cur - SLOT_V;
        end else begin
            sp_next     = sp_cur + SLOT_V;
            access_addr = sp_cur;
        end
    end
endmodule

// File: rtl/regmask_stack_seq.sv
module regmask_stack_seq
    import regmask_pkg::*;
#(
    parameter int MASK_W     = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int SLOT_BYTES = 2,
    parameter int SEL_W      = $clog2(MASK_W),
    parameter int IDX_W      = SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_pop,
    input  logic              word_mode,
    input  logic              upper_bank,
    input  logic [MASK_W-1:0] reg_mask,
    input  logic [ADDR_W-1:0] sp_in,
    output logic [IDX_W-1:0]  rf_idx,
    output logic              rf_word,
    output logic              rf_re,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [DATA_W-1:0] rf_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] sp_out,
    output logic              sp_we,
    output logic              done,
    output logic              busy
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] SLOT_V = ADDR_W'(SLOT_BYTES);

    seq_state_t        state, state_nx;
    logic [MASK_W-1:0] mask_q;
    logic              pop_q, word_q, bank_q;
    logic [ADDR_W-1:0] sp_q;

    logic [SEL_W-1:0]  pick_idx;
    logic [MASK_W-1:0] pick_hot;
    logic [MASK_W-1:0] mask_left;
    logic [ADDR_W-1:0] acc_addr, sp_nx;

    regmask_pick #(.W(MASK_W), .IDX_W(SEL_W)) u_pick (
        .bits     (mask_q),
        .from_top (!pop_q),
        .idx      (pick_idx),
        .onehot   (pick_hot)
    );

    regmask_sp_step #(.ADDR_W(ADDR_W), .SLOT_BYTES(SLOT_BYTES)) u_step (
        .sp_cur      (sp_q),
        .go_down     (!pop_q),
        .access_addr (acc_addr),
        .sp_next     (sp_nx)
    );

    assign mask_left = mask_q & ~pick_hot;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = (reg_mask == '0) ? ST_FINISH : ST_XFER;
            ST_XFER:   if (mask_left == '0) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            mask_q <= '0;
            pop_q  <= 1'b0;
            word_q <= 1'b0;
            bank_q <= 1'b0;
            sp_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                mask_q <= reg_mask;
                pop_q  <= is_pop;
                word_q <= word_mode;
                bank_q <= upper_bank;
                sp_q   <= sp_in;
            end else if (state == ST_XFER) begin
                mask_q <= mask_left;
                sp_q   <= sp_nx;
            end
        end
    end

    always_comb begin
        rf_idx    = {bank_q, pick_idx};
        rf_word   = word_q;
        rf_re     = 1'b0;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        mem_addr  = acc_addr;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_re    = 1'b0;
        sp_out    = sp_q;
        sp_we     = 1'b0;
        done      = 1'b0;
        busy      = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: ;
            ST_XFER: begin
                if (pop_q) begin
                    mem_re   = 1'b1;
                    rf_we    = 1'b1;
                    rf_wdata = word_q ? mem_rdata
                                      : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
                end else begin
                    rf_re     = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = word_q ? rf_rdata
                                       : {{(DATA_W-BYTE_W){1'b0}}, rf_rdata[BYTE_W-1:0]};
                end
            end
            ST_FINISH: begin
                sp_we = 1'b1;
                done  = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !done && !mem_we && !rf_we);

    // R2
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re) && !(rf_we && rf_re));

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && !pop_q) |=> sp_q == $past(sp_q) - SLOT_V);

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && pop_q) |=> sp_q == $past(sp_q) + SLOT_V);

    // R6
    byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !word_q) |-> mem_wdata[DATA_W-1:BYTE_W] == '0);

    // R7
    one_pick_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pick_hot));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R9
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && reg_mask == '0) |=> done && sp_out == $past(sp_in));

    // R10
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(pop_q) && $stable(word_q) && $stable(bank_q));
endmodule

// File: tb/regmask_stack_seq_test.sv
module regmask_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_pop = 1'b0, word_mode = 1'b0, upper_bank = 1'b0;
    logic [7:0]  reg_mask = '0;
    logic [15:0] sp_in = '0;
    logic [3:0]  rf_idx;
    logic        rf_word, rf_re, rf_we, mem_we, mem_re, sp_we, done, busy;
    logic [15:0] rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, sp_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    regmask_stack_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_pop(is_pop), .word_mode(word_mode),
        .upper_bank(upper_bank), .reg_mask(reg_mask), .sp_in(sp_in),
        .rf_idx(rf_idx), .rf_word(rf_word), .rf_re(rf_re), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_wdata(rf_wdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .sp_out(sp_out), .sp_we(sp_we), .done(done), .busy(busy)
    );

    logic [15:0] wregs [16];
    logic [7:0]  bregs [16];
    logic [15:0] mem   [128];

    assign rf_rdata  = rf_word ? wregs[rf_idx] : {8'hA5, bregs[rf_idx]};
    assign mem_rdata = mem[mem_addr[7:1]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:1]] <= mem_wdata;
        if (rf_we) begin
            if (rf_word) wregs[rf_idx] <= rf_wdata;
            else         bregs[rf_idx] <= rf_wdata[7:0];
        end
    end

    typedef struct {
        int          kind;   // 0 store, 1 load, 2 finish
        logic [15:0] addr;
        logic [15:0] data;
        logic [3:0]  idx;
        string       req;
    } ev_t;
    ev_t sb[$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: compare every strobe against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && (mem_we || rf_we || done)) begin
            ev_t e;
            int k;
            k = mem_we ? 0 : (rf_we ? 1 : 2);
            if (sb.size() == 0) begin
                check(1'b0, "R10", "unexpected activity", 32'(k), 32'hFF);
            end else begin
                e = sb.pop_front();
                check(e.kind == k, e.req, "event kind", 32'(k), 32'(e.kind));
                if (k == 0) begin
                    check(mem_addr == e.addr, "R3", "store addr", mem_addr, e.addr);
                    check(mem_wdata == e.data, e.req, "store data", mem_wdata, e.data);
                    check(rf_idx == e.idx, "R5", "store idx", rf_idx, e.idx);
                end else if (k == 1) begin
                    check(mem_addr == e.addr, "R4", "load addr", mem_addr, e.addr);
                    check(rf_wdata == e.data, e.req, "load data", rf_wdata, e.data);
                    check(rf_idx == e.idx, "R5", "load idx", rf_idx, e.idx);
                end else begin
                    check(sp_we, "R8", "sp_we with done", 32'(sp_we), 32'd1);
                    check(sp_out == e.addr, e.req, "final sp", sp_out, e.addr);
                end
            end
        end
    end

    task automatic run_op(input bit pop, input bit wm, input bit ub, input logic [7:0] m,
                          input logic [15:0] sp, input bit poke_mid, input bit poke_done);
        logic [15:0] s;
        int n;
        int cnt;
        ev_t e;
        s = sp;
        n = 0;
        if (!pop) begin
            for (int i = 7; i >= 0; i--) if (m[i]) begin
                s = s - 16'd2;
                e.kind = 0; e.addr = s; e.idx = {ub, 3'(i)};
                e.data = wm ? wregs[{ub, 3'(i)}] : {8'h00, bregs[{ub, 3'(i)}]};
                e.req = wm ? "R2" : "R6";
                sb.push_back(e);
                n++;
            end
        end else begin
            for (int i = 0; i <= 7; i++) if (m[i]) begin
                e.kind = 1; e.addr = s; e.idx = {ub, 3'(i)};
                e.data = wm ? mem[s[7:1]] : {8'h00, mem[s[7:1]][7:0]};
                e.req = wm ? "R4" : "R6";
                sb.push_back(e);
                s = s + 16'd2;
                n++;
            end
        end
        e.kind = 2; e.addr = s; e.data = '0; e.idx = '0;
        e.req = (m == 8'h00) ? "R9" : "R8";
        sb.push_back(e);

        @(negedge clk);
        start = 1'b1; is_pop = pop; word_mode = wm; upper_bank = ub;
        reg_mask = m; sp_in = sp;
        @(posedge clk);
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (cnt == 1 && poke_mid) begin
                start = 1'b1; is_pop = !pop; word_mode = !wm; upper_bank = !ub;
                reg_mask = 8'hFF; sp_in = 16'h0010;
            end else if (!(done && poke_done)) begin
                start = 1'b0;
            end
            if (done) break;
            if (cnt > 20) break;
        end
        check(cnt == n + 1, (m == 8'h00) ? "R9" : "R7", "cycles to done", 32'(cnt), 32'(n + 1));
        if (poke_done) begin
            start = 1'b1; reg_mask = 8'hFF; is_pop = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
        check(!busy && !done, "R10", "idle after done", {30'd0, busy, done}, 32'd0);
        check(sb.size() == 0, "R7", "scoreboard drained", 32'(sb.size()), 32'd0);
        sb.delete();
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            wregs[i] = 16'h1000 * 16'(i) + 16'h0101 * 16'(i) + 16'h0042;
            bregs[i] = 8'h30 + 8'(i);
        end
        for (int i = 0; i < 128; i++) mem[i] = 16'hC300 + 16'(i * 7);
        repeat (3) @(negedge clk);
        // R1
        check(!done && !busy && !sp_we && !mem_we && !mem_re && !rf_we && !rf_re, "R1",
              "reset outputs", {25'd0, done, busy, sp_we, mem_we, mem_re, rf_we, rf_re}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R5: word push, lower bank
        run_op(1'b0, 1'b1, 1'b0, 8'b1010_0110, 16'h0080, 1'b0, 1'b0);
        // R4: word pop of the same slots
        run_op(1'b1, 1'b1, 1'b0, 8'b1010_0110, 16'h0078, 1'b0, 1'b0);
        // R6 R10: byte push, upper bank, start mid-operation
        run_op(1'b0, 1'b0, 1'b1, 8'h81, 16'h00F0, 1'b1, 1'b0);
        // R6: byte pop of all upper registers over slots with non-zero high bytes
        run_op(1'b1, 1'b0, 1'b1, 8'hFF, 16'h0040, 1'b0, 1'b0);
        // R9 R10: empty push with start during done
        run_op(1'b0, 1'b1, 1'b0, 8'h00, 16'h1234, 1'b0, 1'b1);
        // R9: empty pop
        run_op(1'b1, 1'b0, 1'b1, 8'h00, 16'h0ABC, 1'b0, 1'b0);
        // R7 R10: full word push, upper bank, both intrusions
        run_op(1'b0, 1'b1, 1'b1, 8'hFF, 16'h0100, 1'b1, 1'b1);
        // R4 R7: single top bit pop
        run_op(1'b1, 1'b1, 1'b0, 8'h80, 16'h0020, 1'b0, 1'b0);
        // R2: single bottom bit push in byte mode
        run_op(1'b0, 1'b0, 1'b0, 8'h01, 16'h0002, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule